// File: doc/BRIEF.md
# Switching-Frequency Data Link: Transmit Divider and Loop-Code Demodulator

This block carries a slow bit stream across an isolation transformer by moving the converter switching frequency between a nominal rate and a second, lower rate. It has two independent halves. The transmit half is a clock divider. It produces one reference tick per switching period. At every period boundary it selects one of two division lengths from the outgoing data bit.

The receive half never looks at the switching waveform itself. It watches the control code that the local phase-locked loop's filter drives into its oscillator. When the far end moves its frequency, the loop pulls this code away from its settled value. The block first learns the settled (nominal) code, taken the first time the loop reports lock while the link is idle. After that, each strobed code sample is classified by the sign and size of its departure from the nominal code. A debounce run filters out loop transients. A fixed bit period, counted in switching-period samples and known to both ends, sets when each decoded bit is emitted.

Top module: `fsk_ctrl_demod`

## Requirements
- R1: While rst_ni is low, data_o, valid_o and tx_tick_o are all 0.
- R2: With tx_en_i low, tx_tick_o pulses for one cycle every DIV_NOM clock cycles (default 25), whatever tx_data_i is.
- R3: With tx_en_i high, tx_data_i is sampled in the cycle tx_tick_o is high. A 1 makes the following period DIV_MOD cycles long (default 27, the lower frequency). A 0 makes it DIV_NOM cycles long.
- R4: The nominal code is loaded from code_i in the first cycle after reset in which lock_i is 1 and comm_en_i is 0. Later lock events never reload it.
- R5: valid_o stays 0 while comm_en_i is 0 and until the nominal code has been loaded.
- R6: Once decoding is active, valid_o pulses for exactly one cycle, in the cycle after every BIT_SAMPLES-th (default 8) sample_i strobe. Counting starts at the first strobe after comm_en_i rises.
- R7: A sample counts as the modulated side when nominal − code_i ≥ thresh_i. Otherwise it counts as the nominal side, and this includes codes above the nominal. The modulated side decodes as data 1 and the nominal side as data 0.
- R8: The decided level changes only after persist_i consecutive samples on the other side. A run that is broken earlier is discarded. A persist_i of 0 behaves as 1.
- R9: lock_i has no effect on decoding once the nominal code is loaded.
- R10: Dropping comm_en_i returns the decided level to 0, clears the run, and restarts the bit-period count.
- R11: data_o changes only in a cycle where valid_o is 1. At each strobe it presents the level decided after the bit period's last sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit modulation enable |
| tx_data_i | input | 1 | Outgoing data bit |
| tx_tick_o | output | 1 | One pulse per transmit switching period |
| sample_i | input | 1 | One strobe per received switching period |
| code_i | input | CODE_W | Loop-filter control code |
| lock_i | input | 1 | Loop lock indication |
| comm_en_i | input | 1 | Receive decoding enable |
| thresh_i | input | CODE_W | Minimum departure that counts as modulated |
| persist_i | input | RUN_W | Samples needed to change the decided level |
| data_o | output | 1 | Decoded bit |
| valid_o | output | 1 | Decoded bit strobe |

## Verification
A wrong nominal code shows up as decoded bits stuck at 0, or stuck at 1, from the very first bit period after enable. A corrupted bit-period counter moves valid_o away from the eighth strobe of a period, and that is visible within one bit. A faulty debounce run shows up in the single bit where a short or exact-length run is sent, because data_o then differs from the requirement at that strobe. A wrong division length on the transmit side changes the measured tick interval already in the first period after a tick.

// File: rtl/fsk_demod_pkg.sv
package fsk_demod_pkg;
  typedef enum logic {SIDE_NOM = 1'b0, SIDE_MOD = 1'b1} side_e;
endpackage

// File: rtl/fsk_tx_divider.sv
module fsk_tx_divider #(
  parameter int DIV_NOM = 25,
  parameter int DIV_MOD = 27
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic data_i,
  output logic tick_o
);
  localparam int DIV_MAX = (DIV_NOM > DIV_MOD) ? DIV_NOM : DIV_MOD;
  localparam int CW = $clog2(DIV_MAX);
  localparam logic [CW-1:0] LAST_NOM = CW'(DIV_NOM - 1);
  localparam logic [CW-1:0] LAST_MOD = CW'(DIV_MOD - 1);

  logic [CW-1:0] cnt_q, last_q;
  logic wrap;

  assign wrap   = (cnt_q == last_q);
  assign tick_o = wrap;

  // length for the next period is chosen only at the boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      last_q <= LAST_NOM;
    end else if (wrap) begin
      cnt_q  <= '0;
      last_q <= (en_i && data_i) ? LAST_MOD : LAST_NOM;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fsk_nominal_latch.sv
module fsk_nominal_latch #(
  parameter int CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              comm_en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] nom_o,
  output logic              ok_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nom_o <= '0;
      ok_o  <= 1'b0;
    end else if (!ok_o && lock_i && !comm_en_i) begin
      nom_o <= code_i;
      ok_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/fsk_dev_classify.sv
module fsk_dev_classify
  import fsk_demod_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter bit ONE_IS_LOW = 1'b1
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] nom_i,
  input  logic [CODE_W-1:0] thresh_i,
  output side_e             side_o
);
  localparam int DW = CODE_W + 2;

  logic signed [DW-1:0] dev, mag, thr;

  assign dev = $signed({2'b00, code_i}) - $signed({2'b00, nom_i});
  assign thr = $signed({2'b00, thresh_i});

  generate
    if (ONE_IS_LOW) begin : g_low
      assign mag = -dev;
    end else begin : g_high
      assign mag = dev;
    end
  endgenerate

  assign side_o = (mag >= thr) ? SIDE_MOD : SIDE_NOM;
endmodule

// File: rtl/fsk_bit_slicer.sv
module fsk_bit_slicer
  import fsk_demod_pkg::*;
#(
  parameter int BIT_SAMPLES = 8,
  parameter int RUN_W       = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             sample_i,
  input  side_e            side_i,
  input  logic [RUN_W-1:0] persist_i,
  output logic             data_o,
  output logic             valid_o
);
  localparam int BW = (BIT_SAMPLES > 2) ? $clog2(BIT_SAMPLES) : 1;
  localparam logic [BW-1:0] LAST_IDX = BW'(BIT_SAMPLES - 1);

  side_e            level_q, level_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic [BW-1:0]    idx_q;

  // debounce: a flip needs persist_i samples in a row on the other side
  always_comb begin
    level_d = level_q;
    run_d   = '0;
    if (side_i != level_q) begin
      if (({1'b0, run_q} + 1'b1) >= {1'b0, persist_i}) begin
        level_d = side_i;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= SIDE_NOM;
      run_q   <= '0;
      idx_q   <= '0;
      data_o  <= 1'b0;
      valid_o <= 1'b0;
    end else if (!active_i) begin
      level_q <= SIDE_NOM;
      run_q   <= '0;
      idx_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (sample_i) begin
        level_q <= level_d;
        run_q   <= run_d;
        if (idx_q == LAST_IDX) begin
          idx_q   <= '0;
          valid_o <= 1'b1;
          data_o  <= (level_d == SIDE_MOD);
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fsk_ctrl_demod.sv
module fsk_ctrl_demod
  import fsk_demod_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int RUN_W       = 4,
  parameter int BIT_SAMPLES = 8,
  parameter int DIV_NOM     = 25,
  parameter int DIV_MOD     = 27,
  parameter bit ONE_IS_LOW  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              tx_data_i,
  output logic              tx_tick_o,
  input  logic              sample_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              lock_i,
  input  logic              comm_en_i,
  input  logic [CODE_W-1:0] thresh_i,
  input  logic [RUN_W-1:0]  persist_i,
  output logic              data_o,
  output logic              valid_o
);
  logic [CODE_W-1:0] nom;
  logic              nom_ok;
  side_e             side;

  fsk_tx_divider #(.DIV_NOM(DIV_NOM), .DIV_MOD(DIV_MOD)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tx_en_i),
    .data_i (tx_data_i),
    .tick_o (tx_tick_o)
  );

  fsk_nominal_latch #(.CODE_W(CODE_W)) u_nom (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lock_i    (lock_i),
    .comm_en_i (comm_en_i),
    .code_i    (code_i),
    .nom_o     (nom),
    .ok_o      (nom_ok)
  );

  fsk_dev_classify #(.CODE_W(CODE_W), .ONE_IS_LOW(ONE_IS_LOW)) u_cls (
    .code_i   (code_i),
    .nom_i    (nom),
    .thresh_i (thresh_i),
    .side_o   (side)
  );

  fsk_bit_slicer #(.BIT_SAMPLES(BIT_SAMPLES), .RUN_W(RUN_W)) u_slc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (comm_en_i && nom_ok),
    .sample_i  (sample_i),
    .side_i    (side),
    .persist_i (persist_i),
    .data_o    (data_o),
    .valid_o   (valid_o)
  );
endmodule

// File: rtl/fsk_demod_chk.sv
module fsk_demod_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_tick_o,
  input logic sample_i,
  input logic comm_en_i,
  input logic data_o,
  input logic valid_o
);
  assert_tick_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_tick_o |=> !tx_tick_o);

  assert_valid_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_valid_after_sample_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(sample_i));

  assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(comm_en_i) |-> !valid_o);

  assert_data_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));
endmodule

bind fsk_ctrl_demod fsk_demod_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_tick_o (tx_tick_o),
  .sample_i  (sample_i),
  .comm_en_i (comm_en_i),
  .data_o    (data_o),
  .valid_o   (valid_o)
);

// File: tb/fsk_ctrl_demod_tb_top.sv
module fsk_ctrl_demod_tb_top;
  localparam int CODE_W = 12;
  localparam int RUN_W  = 4;
  localparam int BITS   = 8;
  localparam int NOMC   = 2000;
  localparam int MODC   = 1900;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              tx_en_i = 1'b0, tx_data_i = 1'b0;
  logic              tx_tick_o;
  logic              sample_i = 1'b0;
  logic [CODE_W-1:0] code_i = '0;
  logic              lock_i = 1'b0, comm_en_i = 1'b0;
  logic [CODE_W-1:0] thresh_i = 12'd40;
  logic [RUN_W-1:0]  persist_i = 4'd3;
  logic              data_o, valid_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fsk_ctrl_demod dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tx_en_i(tx_en_i), .tx_data_i(tx_data_i),
    .tx_tick_o(tx_tick_o), .sample_i(sample_i), .code_i(code_i), .lock_i(lock_i),
    .comm_en_i(comm_en_i), .thresh_i(thresh_i), .persist_i(persist_i),
    .data_o(data_o), .valid_o(valid_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one bit period: sample j uses the modulated code when mask[j] is set
  task automatic send_bit(logic [BITS-1:0] mask, int mc, int nc, int exp, string req, bit wiggle);
    int prev;
    prev = int'(data_o);
    for (int j = 0; j < BITS; j++) begin
      code_i = CODE_W'(mask[j] ? mc : nc);
      if (wiggle) lock_i = ~lock_i;
      sample_i = 1'b1;
      tick();
      sample_i = 1'b0;
      if (j < BITS - 1) begin
        chk(req, "no strobe mid-bit", int'(valid_o), 0);
        chk("R11", "data held mid-bit", int'(data_o), prev);
      end else begin
        chk("R6", "strobe at last sample", int'(valid_o), 1);
        chk(req, "decoded bit", int'(data_o), exp);
      end
      tick();
    end
  endtask

  task automatic measure(output int n);
    while (!tx_tick_o) tick();
    n = 0;
    do begin
      tick();
      n++;
    end while (!tx_tick_o);
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk("R1", "data_o in reset", int'(data_o), 0);
    chk("R1", "valid_o in reset", int'(valid_o), 0);
    chk("R1", "tx_tick_o in reset", int'(tx_tick_o), 0);
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic t_tx();
    int n;
    tx_en_i = 1'b0; tx_data_i = 1'b1;
    for (int k = 0; k < 2; k++) begin
      measure(n);
      chk("R2", "idle period", n, 25);
    end
    tx_en_i = 1'b1;
    for (int k = 0; k < 2; k++) begin
      measure(n);
      chk("R3", "period for data 1", n, 27);
    end
    tx_data_i = 1'b0;
    measure(n);
    chk("R3", "period for data 0", n, 25);
    tx_en_i = 1'b0;
  endtask

  task automatic t_no_nominal();
    lock_i = 1'b0; comm_en_i = 1'b1;
    for (int j = 0; j < 2 * BITS; j++) begin
      code_i = CODE_W'(MODC);
      sample_i = 1'b1;
      tick();
      sample_i = 1'b0;
      chk("R5", "no strobe before nominal", int'(valid_o), 0);
      tick();
    end
    comm_en_i = 1'b0;
    tick();
  endtask

  task automatic t_capture();
    code_i = CODE_W'(NOMC); lock_i = 1'b1;
    tick();
    code_i = CODE_W'(1500); lock_i = 1'b0;
    tick();
    lock_i = 1'b1;
    tick();
    for (int j = 0; j < BITS; j++) begin
      sample_i = 1'b1;
      tick();
      sample_i = 1'b0;
      chk("R5", "no strobe while disabled", int'(valid_o), 0);
      tick();
    end
    comm_en_i = 1'b1;
    tick();
    send_bit(8'hFF, MODC, NOMC, 1, "R4", 1'b0);
    send_bit(8'h00, MODC, NOMC, 0, "R4", 1'b0);
    send_bit(8'hFF, MODC, NOMC, 1, "R4", 1'b0);
    send_bit(8'hFF, MODC, NOMC, 1, "R4", 1'b0);
    send_bit(8'h00, MODC, NOMC, 0, "R4", 1'b0);
  endtask

  task automatic restart();
    comm_en_i = 1'b0;
    tick();
    comm_en_i = 1'b1;
    tick();
  endtask

  task automatic t_classify();
    restart();
    send_bit(8'hFF, 1960, NOMC, 1, "R7", 1'b0);
    send_bit(8'hFF, 1961, NOMC, 0, "R7", 1'b0);
    send_bit(8'hFF, MODC, NOMC, 1, "R7", 1'b0);
    send_bit(8'hFF, 2100, NOMC, 0, "R7", 1'b0);
  endtask

  task automatic t_persist();
    restart();
    send_bit(8'b0000_0011, MODC, NOMC, 0, "R8", 1'b0);
    send_bit(8'b1110_0000, MODC, NOMC, 1, "R8", 1'b0);
    send_bit(8'b1100_1001, MODC, NOMC, 1, "R8", 1'b0);
    persist_i = 4'd0;
    send_bit(8'b1000_0000, NOMC, MODC, 0, "R8", 1'b0);
    persist_i = 4'd3;
  endtask

  task automatic t_lock();
    restart();
    send_bit(8'hFF, MODC, NOMC, 1, "R9", 1'b1);
    send_bit(8'h00, MODC, NOMC, 0, "R9", 1'b1);
    send_bit(8'hFF, MODC, NOMC, 1, "R9", 1'b1);
    lock_i = 1'b1;
  endtask

  task automatic t_restart();
    restart();
    send_bit(8'h00, MODC, NOMC, 0, "R10", 1'b0);
    for (int j = 0; j < 4; j++) begin
      code_i = CODE_W'(MODC);
      sample_i = 1'b1;
      tick();
      sample_i = 1'b0;
      chk("R10", "no strobe in partial bit", int'(valid_o), 0);
      tick();
    end
    persist_i = 4'd15;
    restart();
    send_bit(8'hFF, MODC, NOMC, 0, "R10", 1'b0);
    persist_i = 4'd3;
  endtask

  initial begin
    t_reset();
    t_tx();
    t_no_nominal();
    t_capture();
    t_classify();
    t_persist();
    t_lock();
    t_restart();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule